// File: doc/BRIEF.md
# Diagnostic Port Display Sequencer

This block watches a simple write bus (address, write strobe, byte of data) for writes to the diagnostic checkpoint port and shows the last byte written there as two hexadecimal digits on a pair of seven-segment outputs. Firmware writes a progress code to the port at the start of each step. If the system then stalls, the last code written stays on the display.

Three more bus addresses, placed just above a configurable base, form an auxiliary error-detail register. One address takes the high byte of a 16-bit failure bitmap, the next takes the low byte, and the third carries a valid bit. The bitmap has one bit per failing address line or data bit, so 0x0002 means line 1. While the valid bit is set, the display rotates without end through three phases: the checkpoint code, then the bitmap high byte, then the bitmap low byte. Each phase is held for a parameterised number of clock cycles.

Top module: `diag_port_display`

## Requirements
- R1: Only a cycle with `bus_wr` high and `bus_addr` equal to `PORT_ADDR` (default 0x0080) stores `bus_wdata` as the checkpoint code. Writes to any other address, and any address or data presented with `bus_wr` low, leave the checkpoint code unchanged.
- R2: When error mode is off, the displayed byte is the stored checkpoint code. It stays there for as long as no further port write arrives.
- R3: A write to `AUX_BASE` stores the bitmap high byte and a write to `AUX_BASE+1` stores the low byte. A write to `AUX_BASE+2` sets error mode when data bit 0 is 1 and clears it when bit 0 is 0. Every write to `AUX_BASE+2` restarts the rotation at the code phase.
- R4: In error mode the displayed byte shows the checkpoint code, then the bitmap high byte, then the bitmap low byte. Each is shown for exactly `DWELL` cycles, and the order repeats without end.
- R5: A port write restarts the phase sequence at the code phase with a full dwell.
- R6: A port write turns error mode off. Rotation resumes only after bit 0 of `AUX_BASE+2` is written as 1 again.
- R7: `seg_hi` shows the upper nibble and `seg_lo` the lower nibble of the displayed byte. Segments are active high, with bit 0 = a through bit 6 = g. The glyphs 0..F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R8: After synchronous reset the checkpoint code is 0x00 and error mode is off. `disp_byte` is 0x00 and both digits show 0x3F.
- R9: The outputs are registered. A change of internal state made at clock edge k appears on `disp_byte`, `seg_hi` and `seg_lo` after edge k+1.
- R10: The bitmap bytes are shown unchanged. For example, bitmap 0x0002 shows 0x00 in the high phase and 0x02 in the low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Write address |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| disp_byte | output | 8 | Byte currently shown (registered) |
| seg_hi | output | 7 | Upper digit segments a..g, active high |
| seg_lo | output | 7 | Lower digit segments a..g, active high |

## Verification
A corrupted phase or dwell count shows up on `disp_byte` within one dwell period. The wrong byte appears, or the right byte changes a cycle early or late. A stale error-mode flag keeps the bitmap bytes rotating after a port write, when only the code should be shown. This is visible `DWELL` cycles after that write. A bad glyph entry shows only when that nibble is displayed, so the bench walks all sixteen values through both digits.

// File: rtl/diag_disp_pkg.sv
package diag_disp_pkg;

  typedef enum logic [1:0] {
    PH_CODE = 2'd0,
    PH_HI   = 2'd1,
    PH_LO   = 2'd2
  } phase_e;

  localparam int SEG_W = 7;

  // Active-high segments, bit0 = a ... bit6 = g
  function automatic logic [SEG_W-1:0] hex_glyph(input logic [3:0] nib);
    logic [SEG_W-1:0] s;
    case (nib)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/diag_bus_decode.sv
module diag_bus_decode #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0080,
  parameter logic [ADDR_W-1:0] AUX_BASE  = 16'h0084
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        code_q,
  output logic [7:0]        bmp_hi_q,
  output logic [7:0]        bmp_lo_q,
  output logic              err_q,
  output logic              restart
);

  localparam logic [ADDR_W-1:0] HI_ADDR  = AUX_BASE;
  localparam logic [ADDR_W-1:0] LO_ADDR  = ADDR_W'(AUX_BASE + 1);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(AUX_BASE + 2);

  logic hit_port, hit_hi, hit_lo, hit_ctl;

  always_comb begin
    hit_port = bus_wr && (bus_addr == PORT_ADDR);
    hit_hi   = bus_wr && (bus_addr == HI_ADDR);
    hit_lo   = bus_wr && (bus_addr == LO_ADDR);
    hit_ctl  = bus_wr && (bus_addr == CTL_ADDR);
    restart  = hit_port || hit_ctl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= 8'h00;
      bmp_hi_q <= 8'h00;
      bmp_lo_q <= 8'h00;
      err_q    <= 1'b0;
    end else begin
      if (hit_port) begin
        code_q <= bus_wdata;
        err_q  <= 1'b0;
      end
      if (hit_hi) bmp_hi_q <= bus_wdata;
      if (hit_lo) bmp_lo_q <= bus_wdata;
      if (hit_ctl) err_q <= bus_wdata[0];
    end
  end

endmodule

// File: rtl/diag_phase_seq.sv
module diag_phase_seq
  import diag_disp_pkg::*;
#(
  parameter int DWELL = 25_000_000,
  parameter int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_q,
  input  logic             restart,
  output phase_e           phase_q,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);

  always_ff @(posedge clk) begin
    if (rst || restart || !err_q) begin
      phase_q <= PH_CODE;
      cnt_q   <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      case (phase_q)
        PH_CODE: phase_q <= PH_HI;
        PH_HI:   phase_q <= PH_LO;
        default: phase_q <= PH_CODE;
      endcase
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/diag_seg_encode.sv
module diag_seg_encode
  import diag_disp_pkg::*;
#(
  parameter int NUM_DIGITS = 2,
  localparam int BYTE_W    = 4 * NUM_DIGITS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [BYTE_W-1:0]           val,
  output logic [BYTE_W-1:0]           val_q,
  output logic [NUM_DIGITS*SEG_W-1:0] seg_q
);

  always_ff @(posedge clk) begin
    if (rst) val_q <= '0;
    else     val_q <= val;
  end

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    always_ff @(posedge clk) begin
      if (rst) seg_q[d*SEG_W +: SEG_W] <= hex_glyph(4'h0);
      else     seg_q[d*SEG_W +: SEG_W] <= hex_glyph(val[d*4 +: 4]);
    end
  end

endmodule

// File: rtl/diag_port_display.sv
module diag_port_display
  import diag_disp_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0080,
  parameter logic [ADDR_W-1:0] AUX_BASE  = 16'h0084,
  parameter int                DWELL     = 25_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        disp_byte,
  output logic [6:0]        seg_hi,
  output logic [6:0]        seg_lo
);

  localparam int CNT_W      = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam int NUM_DIGITS = 2;

  logic [7:0]       code_q, bmp_hi_q, bmp_lo_q;
  logic             err_q, restart;
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       shown;
  logic [NUM_DIGITS*SEG_W-1:0] seg_all;

  diag_bus_decode #(
    .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .AUX_BASE(AUX_BASE)
  ) u_dec (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .code_q(code_q), .bmp_hi_q(bmp_hi_q),
    .bmp_lo_q(bmp_lo_q), .err_q(err_q), .restart(restart)
  );

  diag_phase_seq #(.DWELL(DWELL), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .err_q(err_q), .restart(restart),
    .phase_q(phase_q), .cnt_q(cnt_q)
  );

  always_comb begin
    shown = code_q;
    if (err_q) begin
      case (phase_q)
        PH_HI:   shown = bmp_hi_q;
        PH_LO:   shown = bmp_lo_q;
        default: shown = code_q;
      endcase
    end
  end

  diag_seg_encode #(.NUM_DIGITS(NUM_DIGITS)) u_enc (
    .clk(clk), .rst(rst), .val(shown), .val_q(disp_byte), .seg_q(seg_all)
  );

  assign seg_lo = seg_all[SEG_W-1:0];
  assign seg_hi = seg_all[2*SEG_W-1:SEG_W];

endmodule

// File: rtl/diag_port_display_chk.sv
module diag_port_display_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0080,
  parameter int                DWELL     = 4,
  parameter int                CNT_W     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        code_q,
  input logic              err_q,
  input logic              restart,
  input logic [1:0]        phase_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [7:0]        disp_byte
);

  logic port_wr;
  assign port_wr = bus_wr && (bus_addr == PORT_ADDR);

  AST_PORT_STORE: assert property (@(posedge clk) disable iff (rst)
    port_wr |=> code_q == $past(bus_wdata)); // R1

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !port_wr |=> $stable(code_q)); // R2

  AST_IDLE_SHOWS_CODE: assert property (@(posedge clk) disable iff (rst)
    !err_q |=> disp_byte == $past(code_q)); // R9

  AST_PORT_RESTART: assert property (@(posedge clk) disable iff (rst)
    port_wr |=> (phase_q == 2'd0) && (cnt_q == '0)); // R5

  AST_PORT_CLEARS_ERR: assert property (@(posedge clk) disable iff (rst)
    port_wr |=> !err_q); // R6

  AST_WRAP_TO_CODE: assert property (@(posedge clk) disable iff (rst)
    (err_q && !restart && phase_q == 2'd2 && cnt_q == CNT_W'(DWELL - 1))
      |=> phase_q == 2'd0); // R4

endmodule

bind diag_port_display diag_port_display_chk #(
  .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .DWELL(DWELL), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/tb_diag_port_display.sv
module tb_diag_port_display;

  localparam int DW = 4;
  localparam logic [15:0] PORT = 16'h0080;
  localparam logic [15:0] AUXB = 16'h0084;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  disp_byte;
  logic [6:0]  seg_hi, seg_lo;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R8";

  diag_port_display #(.ADDR_W(16), .PORT_ADDR(PORT), .AUX_BASE(AUXB), .DWELL(DW)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .disp_byte(disp_byte), .seg_hi(seg_hi), .seg_lo(seg_lo)
  );

  always #10 clk = ~clk; // 50 MHz

  function automatic logic [6:0] glyph(input logic [3:0] n);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[n];
  endfunction

  // Behavioural reference: state and expected registered output
  logic [7:0] m_code, m_hi, m_lo, e_disp;
  bit m_err;
  int m_ph, m_cnt;
  bit m_valid = 0;

  always @(posedge clk) begin
    bit rs, old_err;
    if (rst) begin
      m_code = 0; m_hi = 0; m_lo = 0; m_err = 0; m_ph = 0; m_cnt = 0; e_disp = 0;
    end else begin
      e_disp = !m_err ? m_code : (m_ph == 0 ? m_code : (m_ph == 1 ? m_hi : m_lo));
      rs = 0; old_err = m_err;
      if (bus_wr) begin
        if (bus_addr == PORT) begin m_code = bus_wdata; m_err = 0; rs = 1; end
        else if (bus_addr == AUXB) m_hi = bus_wdata;
        else if (bus_addr == AUXB + 16'd1) m_lo = bus_wdata;
        else if (bus_addr == AUXB + 16'd2) begin m_err = bus_wdata[0]; rs = 1; end
      end
      if (rs || !old_err) begin m_ph = 0; m_cnt = 0; end
      else if (m_cnt == DW - 1) begin m_cnt = 0; m_ph = (m_ph == 2) ? 0 : m_ph + 1; end
      else m_cnt++;
    end
    m_valid = 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge (R7, R9)
  always @(negedge clk) begin
    if (m_valid) begin
      check(cur_req, "disp_byte", disp_byte, e_disp);
      check("R7", "seg_hi", seg_hi, glyph(e_disp[7:4]));
      check("R7", "seg_lo", seg_lo, glyph(e_disp[3:0]));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state at the ports
    check("R8", "reset disp", disp_byte, 8'h00);
    check("R8", "reset seg_hi", seg_hi, 7'h3F);
    check("R8", "reset seg_lo", seg_lo, 7'h3F);

    cur_req = "R1"; wr(PORT, 8'h5A); idle(2);
    check("R1", "port write shown", disp_byte, 8'h5A);
    wr(16'h0081, 8'h11); wr(16'h0180, 8'h22);
    @(negedge clk); bus_addr = PORT; bus_wdata = 8'h33; idle(3); // strobe low
    check("R1", "ignored writes", disp_byte, 8'h5A);
    cur_req = "R2"; idle(40);
    check("R2", "code held", disp_byte, 8'h5A);

    cur_req = "R10"; wr(AUXB, 8'h00); wr(AUXB + 16'd1, 8'h02);
    check("R3", "bitmap not shown while off", disp_byte, 8'h5A);
    cur_req = "R4"; wr(AUXB + 16'd2, 8'h01); idle(3 * DW * 3);
    cur_req = "R6"; idle(1); wr(PORT, 8'hC7); idle(3 * DW);
    check("R6", "error mode cleared", disp_byte, 8'hC7);
    cur_req = "R3"; wr(AUXB, 8'h10); wr(AUXB + 16'd1, 8'h20);
    wr(AUXB + 16'd2, 8'h01); idle(DW + 2);
    wr(AUXB + 16'd2, 8'h01); idle(2 * DW + 1); // restart mid-rotation
    cur_req = "R5"; wr(PORT, 8'h9E); wr(AUXB + 16'd2, 8'h01); idle(DW + 1);
    wr(PORT, 8'h4B); idle(2); wr(AUXB + 16'd2, 8'h01); idle(4 * DW);
    cur_req = "R3"; wr(AUXB + 16'd2, 8'h00); idle(2 * DW);
    check("R3", "cleared by ctrl", disp_byte, 8'h4B);

    cur_req = "R7";
    for (int i = 0; i < 16; i++) begin
      wr(PORT, 8'((i << 4) | (15 - i))); idle(1);
    end
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule